// File: doc/BRIEF.md
# Leading Run Counter

This block is purely combinational. It scans an input word from its most significant bit downward and reports how many bits in a row match a chosen value. The chosen value is zero or one, fixed at elaboration time. The result carries the run length together with a flag bit. The flag marks a word in which every bit matches. Typical uses are exponent estimation ahead of a separate shifter and priority detection.

The input width is a parameter. When it is not a power of two, the word is first placed in the upper bits of a power-of-two word and the low bits are filled with zeros. Because the fill is always zero, the two modes are not mirror images of each other. A word of all zeros always raises the flag in zero mode. A word of all ones raises the flag in one mode only when the width needs no padding. The count is formed by a binary tree of merge nodes, so the logic depth grows with the logarithm of the width.

Top module: `lead_run_count`

## Requirements
- R1: For every input value, the count equals the number of consecutive matching bits starting at the most significant bit of the padded word.
- R2: The output is $clog2(DATA_W)+1 bits wide. The low $clog2(DATA_W) bits hold the count and the top bit is the all-match flag.
- R3: When DATA_W is not a power of two, the input occupies the top DATA_W bits of a word of the next power-of-two width, and the remaining low bits are zero.
- R4: With MATCH_ZERO=1 and an all-zero input, the flag is 1 and every count bit is 1. For example, 6-bit 000000 gives 1111 and 13-bit zero gives 11111.
- R5: With MATCH_ZERO=0 and an input that is all ones after padding, the flag is 1 and every count bit is 0. For example, 8-bit 11111111 gives 1000.
- R6: With MATCH_ZERO=0 and DATA_W not a power of two, an all-ones input leaves the flag at 0 and gives a count of DATA_W. For example, 6-bit 111111 gives 0110.
- R7: When the flag is 0, the count is at most the padded width minus one. The padded bit directly below the run does not match, and with MATCH_ZERO=0 the count never exceeds DATA_W.
- R8: MATCH_ZERO=1 counts zeros and MATCH_ZERO=0 counts ones. For example, zero mode with 6-bit 001100 gives 0010, and one mode with 6-bit 110011 gives 0010.
- R9: The output follows the input with no clock or storage, and settles within the same cycle in which the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| word_in | input | DATA_W | Word to be scanned from its top bit |
| run_out | output | $clog2(DATA_W)+1 | {all-match flag, run length} |

## Verification
The checker assumes only that the input is a fully defined two-state word of DATA_W bits. It does not depend on any ordering of values over time, because the block keeps no state. The stimulus keeps within this by driving one defined word each cycle. It sweeps all 8192 values of a 13-bit word, and the 6-bit and 8-bit instances take the low bits of that word. This covers every value at the two smaller widths and at the padded width, in both modes.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  // Number of count bits for an input of width w (w >= 2).
  function automatic int cnt_bits(input int w);
    return $clog2(w);
  endfunction

  // Width of the padded word.
  function automatic int pad_width(input int w);
    return 1 << $clog2(w);
  endfunction

endpackage

// File: rtl/lrc_pad.sv
module lrc_pad #(
  parameter int DATA_W     = 13,
  parameter int PW         = 16,
  parameter bit MATCH_ZERO = 1'b1
) (
  input  logic [DATA_W-1:0] word_in,
  output logic [PW-1:0]     hit_vec
);

  localparam int FILL = PW - DATA_W;

  logic [PW-1:0] padded;

  // Data in the top bits; low bits filled with zero.
  always_comb padded = PW'(word_in) << FILL;

  // hit_vec[i] = 1 when padded bit i equals the counted value.
  generate
    if (MATCH_ZERO) begin : g_zero
      always_comb hit_vec = ~padded;
    end else begin : g_one
      always_comb hit_vec = padded;
    end
  endgenerate

endmodule

// File: rtl/lrc_node.sv
module lrc_node #(
  parameter int CW  = 4,
  parameter int LVL = 0
) (
  input  logic          hi_all,
  input  logic [CW-1:0] hi_cnt,
  input  logic          lo_all,
  input  logic [CW-1:0] lo_cnt,
  output logic          all_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] HALF = CW'(1 << LVL);

  // A full upper half contributes 2^LVL on top of the lower run.
  always_comb begin
    all_o = hi_all & lo_all;
    cnt_o = hi_all ? (lo_cnt | HALF) : hi_cnt;
  end

endmodule

// File: rtl/lrc_tree.sv
module lrc_tree #(
  parameter int CW = 4,
  parameter int PW = 16
) (
  input  logic [PW-1:0] hit_vec,
  output logic          root_all,
  output logic [CW-1:0] root_cnt
);

  generate
    for (genvar l = 0; l <= CW; l++) begin : g_lvl
      localparam int N = PW >> l;
      logic [N-1:0]  all_f;
      logic [CW-1:0] cnt_f [N];

      if (l == 0) begin : g_leaf
        assign all_f = hit_vec;
        for (genvar i = 0; i < N; i++) begin : g_c
          assign cnt_f[i] = '0;
        end
      end else begin : g_merge
        for (genvar j = 0; j < N; j++) begin : g_n
          lrc_node #(.CW(CW), .LVL(l-1)) u_node (
            .hi_all (g_lvl[l-1].all_f[2*j+1]),
            .hi_cnt (g_lvl[l-1].cnt_f[2*j+1]),
            .lo_all (g_lvl[l-1].all_f[2*j]),
            .lo_cnt (g_lvl[l-1].cnt_f[2*j]),
            .all_o  (all_f[j]),
            .cnt_o  (cnt_f[j])
          );
        end
      end
    end
  endgenerate

  assign root_all = g_lvl[CW].all_f[0];
  assign root_cnt = g_lvl[CW].cnt_f[0];

endmodule

// File: rtl/lead_run_count.sv
module lead_run_count #(
  parameter int DATA_W     = 13,
  parameter bit MATCH_ZERO = 1'b1
) (
  input  logic [DATA_W-1:0]        word_in,
  output logic [$clog2(DATA_W):0]  run_out
);

  localparam int CW = lrc_pkg::cnt_bits(DATA_W);
  localparam int PW = lrc_pkg::pad_width(DATA_W);
  localparam logic [CW-1:0] FULL_CNT = MATCH_ZERO ? {CW{1'b1}} : {CW{1'b0}};

  logic [PW-1:0] hit_vec;
  logic          root_all;
  logic [CW-1:0] root_cnt;

  lrc_pad #(.DATA_W(DATA_W), .PW(PW), .MATCH_ZERO(MATCH_ZERO)) u_pad (
    .word_in (word_in),
    .hit_vec (hit_vec)
  );

  lrc_tree #(.CW(CW), .PW(PW)) u_tree (
    .hit_vec  (hit_vec),
    .root_all (root_all),
    .root_cnt (root_cnt)
  );

  // Flag on top; fixed fill pattern below when the whole word matches.
  always_comb begin
    run_out = {root_all, (root_all ? FULL_CNT : root_cnt)};
  end

endmodule

// File: rtl/lrc_chk.sv
module lrc_chk #(
  parameter int DATA_W     = 13,
  parameter bit MATCH_ZERO = 1'b1
) (
  input logic [DATA_W-1:0]       word_in,
  input logic [$clog2(DATA_W):0] run_out
);

  localparam int CW = $clog2(DATA_W);
  localparam int PW = 1 << CW;
  localparam logic CV = ~MATCH_ZERO;

  logic [PW-1:0] padded;
  logic          flag;
  logic [CW-1:0] cnt;
  logic          whole;
  logic          run_ok;
  int            pos;

  always_comb begin
    padded = PW'(word_in) << (PW - DATA_W);
    flag   = run_out[CW];
    cnt    = run_out[CW-1:0];
    whole  = MATCH_ZERO ? (word_in == '0) : ((&word_in) && (PW == DATA_W));
    pos    = PW - 1 - int'(cnt);
    run_ok = 1'b1;
    for (int k = 0; k < PW; k++) begin
      if (k > pos && padded[k] != CV) run_ok = 1'b0;
    end
    if (padded[pos] == CV) run_ok = 1'b0;

    // R3
    flag_iff_chk: assert (flag == whole)
      else $error("flag %0b for input %h", flag, word_in);
    // R4
    if (flag && MATCH_ZERO) fill_zero_chk: assert (cnt == {CW{1'b1}})
      else $error("zero-mode fill %b", cnt);
    // R5
    if (flag && !MATCH_ZERO) fill_one_chk: assert (cnt == '0)
      else $error("one-mode fill %b", cnt);
    // R7
    if (!flag) stop_bit_chk: assert (run_ok)
      else $error("run of %0d inconsistent with %h", cnt, word_in);
    // R6
    if (!flag && !MATCH_ZERO) ones_bound_chk: assert (int'(cnt) <= DATA_W)
      else $error("one-mode count %0d above width", cnt);
  end

endmodule

bind lead_run_count lrc_chk #(.DATA_W(DATA_W), .MATCH_ZERO(MATCH_ZERO)) u_chk (
  .word_in (word_in),
  .run_out (run_out)
);

// File: tb/tb_lead_run_count.sv
module tb_lead_run_count;

  logic clk;
  logic rst_n;
  logic [12:0] stim;

  logic [3:0] z6z, z6o, z8z, z8o;
  logic [4:0] z13z, dut_out;

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  lead_run_count #(.DATA_W(6),  .MATCH_ZERO(1'b1)) dut_w6z (.word_in(stim[5:0]), .run_out(z6z));
  lead_run_count #(.DATA_W(6),  .MATCH_ZERO(1'b0)) dut_w6o (.word_in(stim[5:0]), .run_out(z6o));
  lead_run_count #(.DATA_W(8),  .MATCH_ZERO(1'b1)) dut_w8z (.word_in(stim[7:0]), .run_out(z8z));
  lead_run_count #(.DATA_W(8),  .MATCH_ZERO(1'b0)) dut_w8o (.word_in(stim[7:0]), .run_out(z8o));
  lead_run_count #(.DATA_W(13), .MATCH_ZERO(1'b1)) dut_w13z(.word_in(stim),      .run_out(z13z));
  lead_run_count #(.DATA_W(13), .MATCH_ZERO(1'b0)) dut     (.word_in(stim),      .run_out(dut_out));

  typedef struct {
    int         cfg;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  function automatic int cfg_w(input int c);
    return (c < 2) ? 6 : (c < 4) ? 8 : 13;
  endfunction

  // Reference: scan the zero-filled padded word from the top.
  function automatic logic [4:0] ref_z(input logic [12:0] v, input int c);
    int  w  = cfg_w(c);
    bit  zm = (c % 2) == 0;
    int  cw = $clog2(w);
    int  pw = 1 << cw;
    logic [15:0] p = '0;
    int  n = 0;
    bit  go = 1'b1;
    logic [4:0] r;
    for (int i = 0; i < w; i++) p[pw - w + i] = v[i];
    for (int i = pw - 1; i >= 0; i--) begin
      if (go && (p[i] == !zm)) n++;
      else go = 1'b0;
    end
    if (n == pw) r = zm ? 5'((1 << (cw + 1)) - 1) : 5'(1 << cw);
    else         r = 5'(n);
    return r;
  endfunction

  function automatic logic [4:0] get_out(input int c);
    case (c)
      0: return {1'b0, z6z};
      1: return {1'b0, z6o};
      2: return {1'b0, z8z};
      3: return {1'b0, z8o};
      4: return z13z;
      default: return dut_out;
    endcase
  endfunction

  task automatic push(input int c, input logic [4:0] e, input string t);
    item_t it;
    it.cfg = c; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  // Drive a word; expect reference results on all six configurations (R1).
  task automatic apply(input logic [12:0] v);
    @(posedge clk); #1;
    stim = v;
    for (int c = 0; c < 6; c++) push(c, ref_z(v, c), "R1");
  endtask

  // Drive a word; expect a hand-derived result on one configuration.
  task automatic apply_one(input logic [12:0] v, input int c, input logic [4:0] e, input string t);
    @(posedge clk); #1;
    stim = v;
    push(c, e, t);
  endtask

  // Monitor: half a cycle after the drive, no clock edge in between (R9).
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [4:0] got;
      it  = q.pop_front();
      got = get_out(it.cfg);
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s cfg%0d in=%h got=%b exp=%b", it.tag, it.cfg, stim, got, it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    stim  = '0;
    // Reset-time state: all-zero input, zero mode, 13-bit (R4)
    apply_one(13'h0, 4, 5'b11111, "R4");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R4: all-zero inputs in zero mode
    apply_one(13'h0, 0, 5'b01111, "R4");
    apply_one(13'h0, 2, 5'b01111, "R4");
    // R5: 8-bit all ones, one mode
    apply_one(13'h0ff, 3, 5'b01000, "R5");
    // R6: 6-bit all ones pads to 11111100
    apply_one(13'h03f, 1, 5'b00110, "R6");
    // R3: 13-bit all ones pads with three zeros -> 13
    apply_one(13'h1fff, 5, 5'b01101, "R3");
    // R8: mode examples
    apply_one(13'h00c, 0, 5'b00010, "R8");
    apply_one(13'h033, 1, 5'b00010, "R8");
    // R2: 8-bit 00010000 -> count 3, flag clear
    apply_one(13'h010, 2, 5'b00011, "R2");
    // R7: longest run short of full, 8-bit 11111110 -> 7
    apply_one(13'h0fe, 3, 5'b00111, "R7");
    // R7: 13-bit 1 in lowest bit, zero mode -> 12
    apply_one(13'h001, 4, 5'b01100, "R7");
    // R9: back-to-back changes each read in their own cycle
    apply_one(13'h1000, 4, 5'b00000, "R9");
    apply_one(13'h0800, 4, 5'b00001, "R9");

    // R1: every 13-bit word, and thus every 6- and 8-bit word
    for (int v = 0; v < 8192; v++) apply(13'(v));

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule